// File: doc/BRIEF.md
# Paced Character Output Port

This block is a memory-mapped output device that takes one character per write and then keeps a minimum gap before it takes the next. The gap is measured in pulses of a slow timebase input, so the same RTL works for any real-time interval the system wants. Once the gap has run out, the port raises its ready flag. At the same moment it sends a one-cycle set request to the interrupt controller.

Software waits for the interrupt or polls the ready flag, then writes the next byte. Only the low byte of the write data is emitted, as a one-cycle valid pulse. A write made while the port is still waiting is dropped without any trace. A read withdraws the pending interrupt through a one-cycle clear request and leaves the ready flag as it was. The read data itself is zero, so the block does not drive it.

Top module: `pco_port`

## Requirements
- R1: While reset is held and right after it is released, `ready_o`, `char_vld_o`, `irq_set_o` and `irq_clr_o` are all 0, and the interval starts counting from the release of reset.
- R2: With the port not ready, the PERIOD-th `tick_i` pulse since reset or since the last accepted write is taken on one clock edge. `ready_o` rises on the next edge. After PERIOD-1 ticks the port is still not ready.
- R3: A write while ready is accepted. On the following edge `char_vld_o` is 1 and `char_o` holds bits [7:0] of `wr_data_i`. On that same edge `ready_o` becomes 0 and `irq_clr_o` pulses, and the interval restarts from zero. A tick in the write cycle does not count.
- R4: A write while not ready is ignored. No character is emitted, `irq_clr_o` does not pulse (unless a read occurs in the same cycle), and the running interval is not restarted.
- R5: A read (`rd_en_i`) gives a one-cycle `irq_clr_o` pulse on the next edge. It leaves `ready_o` unchanged.
- R6: `irq_set_o` pulses for exactly one cycle, on the same edge on which `ready_o` rises. No further set request is made while the port stays ready, whatever the ticks or reads.
- R7: The interval counter stops at PERIOD and does not wrap while the port waits or sits ready.
- R8: `char_vld_o` is a single-cycle pulse, and there is at most one per accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase pulse; one interval unit per pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data; low CHAR_W bits are the character |
| rd_en_i | input | 1 | Read strobe |
| char_vld_o | output | 1 | One-cycle pulse: a character is emitted |
| char_o | output | CHAR_W | Emitted character |
| ready_o | output | 1 | Port accepts a write |
| irq_set_o | output | 1 | One-cycle interrupt set request |
| irq_clr_o | output | 1 | One-cycle interrupt clear request |

## Verification
An accepted write shows its character, its clear request and the drop of ready one edge after the write cycle. A read shows its clear request one edge after the read cycle. Ready and the set request appear one edge after the edge that takes the PERIOD-th tick. The bench drives every strobe for exactly one clock, samples at the falling edge after the edge that is due, and checks the count PERIOD-1 as well as PERIOD. Emitted characters go through a scoreboard queue, so a dropped write that leaks out, or a pulse held too long, shows up as an unexpected item.

// File: rtl/pco_pkg.sv
package pco_pkg;

  // Next interval count: restart wins, otherwise advance on tick up to the limit.
  function automatic int unsigned pco_step(input int unsigned cur,
                                           input logic        adv,
                                           input logic        restart,
                                           input int unsigned lim);
    if (restart)
      return 0;
    else if (adv && (cur < lim))
      return cur + 1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/pco_interval.sv
module pco_interval #(
  parameter int unsigned PERIOD = 16,
  localparam int unsigned CNT_W = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic elapsed_o
);
  import pco_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb
    cnt_d = CNT_W'(pco_step(int'(cnt_q), tick_i, restart_i, PERIOD));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign elapsed_o = (cnt_q == LIMIT);

  // R7
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_o && !restart_i) |=> elapsed_o);

endmodule

// File: rtl/pco_ready_ctl.sv
module pco_ready_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic elapsed_i,
  input  logic wr_en_i,
  input  logic rd_en_i,
  output logic accept_o,
  output logic ready_o,
  output logic irq_set_o,
  output logic irq_clr_o
);
  logic ready_q;
  logic become_ready;

  assign accept_o     = wr_en_i && ready_q;
  assign become_ready = !ready_q && elapsed_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      irq_set_o <= 1'b0;
      irq_clr_o <= 1'b0;
    end else begin
      irq_set_o <= become_ready;
      irq_clr_o <= accept_o || rd_en_i;
      if (accept_o)          ready_q <= 1'b0;
      else if (become_ready) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  // R6
  set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> irq_set_o);

  // R6
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |=> !irq_set_o);

  // R5
  read_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && ready_o && !wr_en_i) |=> (ready_o && irq_clr_o));

  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && ready_o) |=> (!ready_o && irq_clr_o));

endmodule

// File: rtl/pco_emit.sv
module pco_emit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [CHAR_W-1:0] char_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      char_o <= '0;
    end else begin
      vld_o <= accept_i;
      if (accept_i) char_o <= data_i[CHAR_W-1:0];
    end
  end

  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);

endmodule

// File: rtl/pco_port.sv
module pco_port #(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic              char_vld_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              ready_o,
  output logic              irq_set_o,
  output logic              irq_clr_o
);
  logic accept_w;
  logic elapsed_w;

  pco_interval #(.PERIOD(PERIOD)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (accept_w),
    .elapsed_o (elapsed_w)
  );

  pco_ready_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .elapsed_i (elapsed_w),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .accept_o  (accept_w),
    .ready_o   (ready_o),
    .irq_set_o (irq_set_o),
    .irq_clr_o (irq_clr_o)
  );

  pco_emit #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .data_i   (wr_data_i),
    .vld_o    (char_vld_o),
    .char_o   (char_o)
  );

  // R4
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !ready_o) |=> !char_vld_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!ready_o && !char_vld_o && !irq_set_o && !irq_clr_o));

endmodule

// File: tb/pco_port_tb.sv
module pco_port_tb_top;
  localparam int unsigned P  = 5;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdat = '0;
  logic          rd = 1'b0;
  logic          cvld;
  logic [7:0]    cch;
  logic          rdy;
  logic          iset;
  logic          iclr;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  pco_port #(.PERIOD(P), .DATA_W(DW), .CHAR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr), .wr_data_i(wdat),
    .rd_en_i(rd), .char_vld_o(cvld), .char_o(cch), .ready_o(rdy),
    .irq_set_o(iset), .irq_clr_o(iclr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every emitted character must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && cvld) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R8/R4 unexpected char", int'(cch), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cch == e, "R3 char value", int'(cch), int'(e));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  // Driver: pushes the expected char only when its own model says ready.
  task automatic do_write(input logic [DW-1:0] d, input bit model_ready, input bit with_tick);
    if (model_ready) exp_q.push_back(d[7:0]);
    wdat = d; wr = 1'b1; tick = with_tick;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(!rdy && !cvld && !iset && !iclr, "R1 reset outputs", {rdy, cvld, iset, iclr}, 0);
    rst_n = 1'b1;
    idle(1);
    chk(!rdy, "R1 not ready after reset", rdy, 0);

    // R2 boundary: P-1 ticks not enough
    for (int i = 0; i < P - 1; i++) do_tick();
    idle(3);
    chk(!rdy && !iset, "R2 not ready after P-1 ticks", rdy, 0);
    do_tick();
    chk(!rdy, "R2 ready registered one edge later", rdy, 0);
    idle(1);
    chk(rdy, "R2 ready after P ticks", rdy, 1);
    chk(iset, "R6 set request with ready", iset, 1);
    idle(1);
    chk(!iset, "R6 set request one cycle", iset, 0);

    // R5 read clears irq, keeps ready
    do_read();
    chk(iclr && rdy, "R5 read clear, ready kept", {iclr, rdy}, 2'b11);
    idle(1);
    chk(!iclr, "R5 clear one cycle", iclr, 0);

    // R6/R7: many ticks and reads while ready: no new set, ready stays
    begin
      bit saw_set = 0;
      for (int i = 0; i < 20; i++) begin
        tick = 1'b1; rd = (i % 7 == 0);
        @(negedge clk);
        if (iset) saw_set = 1;
      end
      tick = 1'b0; rd = 1'b0;
      idle(1);
      chk(!saw_set, "R6 no repeat set while ready", saw_set, 0);
      chk(rdy, "R7 ready held after long wait", rdy, 1);
    end

    // R3 accepted write: low byte, tick in same cycle ignored
    do_write(16'h1A5, 1'b1, 1'b1);
    chk(cvld && !rdy && iclr, "R3 accept effects", {cvld, rdy, iclr}, 3'b101);
    idle(1);
    chk(!cvld && !iclr, "R8 single-cycle pulses", {cvld, iclr}, 0);

    // R4 dropped write, interval not restarted
    for (int i = 0; i < 2; i++) do_tick();
    do_write(16'h0033, 1'b0, 1'b0);
    chk(!iclr && !rdy && !cvld, "R4 dropped write silent", {iclr, rdy, cvld}, 0);
    for (int i = 0; i < P - 2; i++) do_tick();
    idle(1);
    chk(rdy && iset, "R4 interval kept across dropped write", {rdy, iset}, 2'b11);

    // R3/R5 write and read same cycle: one char, one clear pulse
    rd = 1'b1;
    do_write(16'hFF42, 1'b1, 1'b0);
    rd = 1'b0;
    chk(cvld && iclr && !rdy, "R3 write+read same cycle", {cvld, iclr, rdy}, 3'b110);
    idle(1);
    chk(!iclr, "R5 clear not repeated", iclr, 0);

    // R4 read while not ready: clear pulse, no ready change
    do_read();
    chk(iclr && !rdy, "R4 read while waiting", {iclr, rdy}, 2'b10);

    // third char after a fresh period
    for (int i = 0; i < P; i++) do_tick();
    idle(1);
    chk(rdy, "R2 ready again", rdy, 1);
    do_write(16'h0007, 1'b1, 1'b0);
    idle(2);
    chk(exp_q.size() == 0, "R8 all chars emitted", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule